// File: doc/BRIEF.md
# Execute ALU with Stored Flags and Condition Evaluation

This block is the arithmetic core of an execute stage. It combines two 64-bit operands under a 2-bit function code: add, subtract, bitwise and, or bitwise exclusive or. The result appears on the output in the same cycle.

When the update enable is high, the rising clock edge stores the overflow, zero and sign flags of that result. When the enable is low, the stored flags keep their values. This lets later instructions that do not touch the flags still read the outcome of the last ALU operation.

A 3-bit condition code is evaluated against the stored flags at all times. The resulting true/false signal steers conditional moves and branches. Code 7 is not a valid condition. It reads as false and raises an error output.

Top module: `exec_alu_cc`

## Requirements
- R1: With `alu_fn` = 0, `alu_res` equals `opnd_b + opnd_a` (modulo 2^64), combinationally in the same cycle.
- R2: With `alu_fn` = 1, `alu_res` equals `opnd_b - opnd_a`. The B operand is the minuend.
- R3: With `alu_fn` = 2, `alu_res` equals `opnd_a & opnd_b`. With `alu_fn` = 3, it equals `opnd_a ^ opnd_b`.
- R4: On a flag-updating add, `flg_ov` becomes 1 exactly when both operands have the same bit 63 and the sum's bit 63 differs from it.
- R5: On a flag-updating subtract, `flg_ov` becomes 1 exactly when the operands' bit 63 values differ and the difference's bit 63 differs from that of `opnd_b`.
- R6: On a flag-updating and or xor, `flg_ov` becomes 0.
- R7: On a rising edge with `flg_we` = 1, `flg_zero` takes the value (result == 0) and `flg_neg` takes result bit 63.
- R8: On a rising edge with `flg_we` = 0, all three stored flags keep their values, whatever the operands or function code are.
- R9: `cond_ok` is evaluated from the stored flags, with lt = `flg_neg` ^ `flg_ov`. The codes map as follows: 0 always true, 1 lt | zero, 2 lt, 3 zero, 4 !zero, 5 !lt, 6 !(lt | zero).
- R10: With `cond_fn` = 7, `cond_ok` = 0 and `cond_bad` = 1. For codes 0 to 6, `cond_bad` = 0.
- R11: While `rst_n` is low, the flags read `flg_zero` = 1, `flg_neg` = 0 and `flg_ov` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_a | input | 64 | A operand (subtrahend) |
| opnd_b | input | 64 | B operand (destination side, minuend) |
| alu_fn | input | 2 | 0 add, 1 sub, 2 and, 3 xor |
| flg_we | input | 1 | Store flags of this operation at the edge |
| cond_fn | input | 3 | Condition code to evaluate |
| alu_res | output | 64 | Combinational result |
| flg_ov | output | 1 | Stored signed overflow |
| flg_zero | output | 1 | Stored zero flag |
| flg_neg | output | 1 | Stored sign flag |
| cond_ok | output | 1 | Selected condition holds |
| cond_bad | output | 1 | Condition code is invalid |

## Verification
The hardest states to reach are those where overflow and sign disagree, because only then do the less and greater conditions differ from the raw sign flag. The stimulus reaches them with boundary operands: the most positive value plus one, and the most negative value minus one. It then sweeps all eight condition codes with the update enable low. The flags are also held across operations that would have changed them. A logic operation that follows an overflow checks that the overflow flag is cleared.

// File: rtl/exec_alu_cc.sv
module exec_alu_cc #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [1:0]   alu_fn,
  input  logic         flg_we,
  input  logic [2:0]   cond_fn,
  output logic [W-1:0] alu_res,
  output logic         flg_ov,
  output logic         flg_zero,
  output logic         flg_neg,
  output logic         cond_ok,
  output logic         cond_bad
);
  localparam int MSB = W - 1;

  logic ov_next;
  logic lt, le;

  always_comb begin
    unique case (alu_fn)
      2'd0:    alu_res = opnd_b + opnd_a;
      2'd1:    alu_res = opnd_b - opnd_a;
      2'd2:    alu_res = opnd_a & opnd_b;
      default: alu_res = opnd_a ^ opnd_b;
    endcase
  end

  always_comb begin
    unique case (alu_fn)
      2'd0:    ov_next = (opnd_a[MSB] == opnd_b[MSB]) && (alu_res[MSB] != opnd_b[MSB]);
      2'd1:    ov_next = (opnd_a[MSB] != opnd_b[MSB]) && (alu_res[MSB] != opnd_b[MSB]);
      default: ov_next = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_ov   <= 1'b0;
      flg_zero <= 1'b1;
      flg_neg  <= 1'b0;
    end else if (flg_we) begin
      flg_ov   <= ov_next;
      flg_zero <= (alu_res == '0);
      flg_neg  <= alu_res[MSB];
    end
  end

  assign lt = flg_neg ^ flg_ov;
  assign le = lt | flg_zero;
  assign cond_bad = (cond_fn == 3'd7);

  always_comb begin
    unique case (cond_fn)
      3'd0:    cond_ok = 1'b1;
      3'd1:    cond_ok = le;
      3'd2:    cond_ok = lt;
      3'd3:    cond_ok = flg_zero;
      3'd4:    cond_ok = !flg_zero;
      3'd5:    cond_ok = !lt;
      3'd6:    cond_ok = !le;
      default: cond_ok = 1'b0;
    endcase
  end

  a_r8_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !flg_we |=> $stable({flg_ov, flg_zero, flg_neg}));

  a_r6_logic_clears_ov: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_we && alu_fn[1]) |=> !flg_ov);

  a_r7_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    flg_we |=> (flg_zero == ($past(alu_res) == '0)));

  a_r7_sign_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    flg_we |=> (flg_neg == $past(alu_res[MSB])));

  a_r10_bad_is_false: assert property (@(posedge clk) disable iff (!rst_n)
    cond_bad |-> !cond_ok);

  a_r9_always_true: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_fn == 3'd0) |-> cond_ok);
endmodule

// File: tb/sim_exec_alu_cc.sv
module sim_exec_alu_cc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic [1:0]  alu_fn = '0;
  logic        flg_we = 1'b0;
  logic [2:0]  cond_fn = '0;
  logic [63:0] alu_res;
  logic        flg_ov, flg_zero, flg_neg, cond_ok, cond_bad;

  int checks = 0, failures = 0;

  typedef struct {
    logic [63:0] res;
    logic ov, zf, sf, ct, ce;
    string req;
  } item_t;
  item_t q[$];

  logic m_ov = 1'b0, m_zf = 1'b1, m_sf = 1'b0;

  always #4 clk = ~clk;

  exec_alu_cc u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic cond_model(input logic [2:0] c, input logic ov, zf, sf);
    logic lt;
    lt = sf ^ ov;
    case (c)
      3'd0: return 1'b1;
      3'd1: return lt | zf;
      3'd2: return lt;
      3'd3: return zf;
      3'd4: return !zf;
      3'd5: return !lt;
      3'd6: return !(lt | zf);
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [1:0] fn,
                       input logic we, input logic [2:0] cf, input string req);
    item_t it;
    logic [63:0] r;
    @(negedge clk);
    opnd_a = a; opnd_b = b; alu_fn = fn; flg_we = we; cond_fn = cf;
    case (fn)
      2'd0: r = b + a;
      2'd1: r = b - a;
      2'd2: r = a & b;
      default: r = a ^ b;
    endcase
    if (we) begin
      if (fn == 2'd0)      m_ov = (a[63] == b[63]) && (r[63] != b[63]);
      else if (fn == 2'd1) m_ov = (a[63] != b[63]) && (r[63] != b[63]);
      else                 m_ov = 1'b0;
      m_zf = (r == 64'd0);
      m_sf = r[63];
    end
    it.res = r; it.ov = m_ov; it.zf = m_zf; it.sf = m_sf;
    it.ct = cond_model(cf, m_ov, m_zf, m_sf);
    it.ce = (cf == 3'd7);
    it.req = req;
    q.push_back(it);
  endtask

  task automatic sweep(input string req);
    for (int c = 0; c < 8; c++)
      drive(64'h1234, 64'h9999, 2'd3, 1'b0, 3'(c), (c == 7) ? "R10" : req);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        chk({it.req, " result"}, alu_res, it.res);
        chk({it.req, " flags ov/zf/sf"}, {61'd0, flg_ov, flg_zero, flg_neg}, {61'd0, it.ov, it.zf, it.sf});
        chk({it.req, " cond_ok (R9)"}, {63'd0, cond_ok}, {63'd0, it.ct});
        chk({it.req, " cond_bad (R10)"}, {63'd0, cond_bad}, {63'd0, it.ce});
      end
    end
  end

  initial begin : main
    fork
      begin
        #20;
        chk("R11 reset zero", {63'd0, flg_zero}, 64'd1);
        chk("R11 reset sign", {63'd0, flg_neg}, 64'd0);
        chk("R11 reset ov", {63'd0, flg_ov}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        sweep("R9 reset flags");
        drive(64'd3, 64'd5, 2'd0, 1'b1, 3'd6, "R1 add");
        drive(64'd1, 64'h7fff_ffff_ffff_ffff, 2'd0, 1'b1, 3'd2, "R4 add overflow");
        sweep("R9 ov=1 sf=1");
        drive(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'd0, 1'b1, 3'd3, "R4 neg overflow to zero");
        drive(64'd5, 64'd3, 2'd1, 1'b1, 3'd2, "R2 sub negative");
        sweep("R9 sf=1 ov=0");
        drive(64'd1, 64'h8000_0000_0000_0000, 2'd1, 1'b1, 3'd5, "R5 sub overflow");
        sweep("R9 ov=1 sf=0");
        drive(64'hf0f0, 64'hff00, 2'd2, 1'b1, 3'd4, "R3 and R6");
        drive(64'hdead_beef, 64'hdead_beef, 2'd3, 1'b1, 3'd3, "R3 xor zero R7");
        drive(64'hffff_0000_0000_0001, 64'd1, 2'd1, 1'b0, 3'd3, "R8 hold on sub");
        drive(64'h1, 64'h7fff_ffff_ffff_ffff, 2'd0, 1'b0, 3'd1, "R8 hold on add");
        drive(64'h5, 64'h5, 2'd1, 1'b1, 3'd1, "R2 sub equal R7");
        drive(64'hffff_ffff_ffff_ffff, 64'd0, 2'd1, 1'b1, 3'd6, "R5 sub no overflow");
        sweep("R9 positive");
        repeat (3) @(negedge clk);
      end
      begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule